// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block is a fully associative translation buffer. Each slot holds one page-table entry: a virtual page tag, an 8-bit address-space number, a global flag, a physical page number, separate per-mode read and write permission masks (four privilege modes), a fault-on-read flag, a fault-on-write flag and a valid bit. Pages are 8 KiB. All page ports of the block therefore take the virtual page number, which is bits 13 and up of the virtual address. The caller does that slicing.

A lookup compares the presented page number and address-space number against every slot in parallel. It reports a hit, the matching slot index and the stored entry in the same cycle. New entries are written at a round-robin slot pointer, so no usage history is kept. Three maintenance operations are provided:

- invalidate everything;
- invalidate only the entries that are not global;
- invalidate every entry that would hit for one page number and address-space number.

A side port shows the slot under the pointer and can step the pointer. The depth is a parameter. Its default is 48, which suits instruction translation. For data translation, 64 is the usual setting.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only when a slot is valid, its tag equals `lk_vpn`, and either its global flag is 1 or its stored address-space number equals `lk_asn`.
- R2: The lookup result (`lk_hit`, `lk_idx`, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd`, `lk_fault_wr`, `lk_global`) is combinational on the current contents. A change made by an operation in one cycle is seen by lookups from the next cycle on. On a miss, all lookup payload outputs are zero.
- R3: When several slots match, `lk_idx` and the payload come from the lowest-numbered matching slot.
- R4: An accepted insert writes the slot named by the pointer and replaces whatever was there. The written slot gets tag `ins_vpn`, the given fields, and valid set to 1. The pointer then advances by one and wraps from DEPTH-1 to 0.
- R5: `fl_all` clears every valid bit and sets the pointer to 0 in the following cycle.
- R6: `fl_local` invalidates every slot whose global flag is 0 and leaves global slots unchanged.
- R7: `fl_addr` invalidates every slot that would hit under the R1 rule for `fa_vpn` and `fa_asn`.
- R8: At most one table operation takes effect per cycle. The fixed priority is `fl_all` first, then `ins_en`, then `fl_local`, then `fl_addr`. A lower-priority request in the same cycle is ignored.
- R9: The slot port shows the pointer (`slot_idx`) and that slot's valid bit, tag, address-space number, global flag and physical page. `slot_adv` steps the pointer with the same wrap, unless `fl_all` is asserted. When `slot_adv` and an insert occur together, the pointer steps only once.
- R10: After reset, every slot is invalid and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 30 | Lookup virtual page number |
| lk_asn | input | 8 | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | $clog2(DEPTH) | Lowest matching slot |
| lk_ppn | output | 28 | Physical page of the hit |
| lk_rd_en | output | 4 | Per-mode read enables of the hit |
| lk_wr_en | output | 4 | Per-mode write enables of the hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| lk_global | output | 1 | Global flag of the hit |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | 30 | Page number of the new entry |
| ins_asn | input | 8 | Address-space number of the new entry |
| ins_global | input | 1 | Global flag of the new entry |
| ins_ppn | input | 28 | Physical page of the new entry |
| ins_rd_en | input | 4 | Read enables of the new entry |
| ins_wr_en | input | 4 | Write enables of the new entry |
| ins_fault_rd | input | 1 | Fault-on-read flag of the new entry |
| ins_fault_wr | input | 1 | Fault-on-write flag of the new entry |
| fl_all | input | 1 | Invalidate all slots and reset the pointer |
| fl_local | input | 1 | Invalidate all non-global slots |
| fl_addr | input | 1 | Invalidate the slots matching fa_vpn/fa_asn |
| fa_vpn | input | 30 | Page number for fl_addr |
| fa_asn | input | 8 | Address-space number for fl_addr |
| slot_adv | input | 1 | Step the pointer |
| slot_idx | output | $clog2(DEPTH) | Current pointer |
| slot_valid | output | 1 | Valid bit of the slot under the pointer |
| slot_vpn | output | 30 | Tag of the slot under the pointer |
| slot_asn | output | 8 | Address-space number of that slot |
| slot_global | output | 1 | Global flag of that slot |
| slot_ppn | output | 28 | Physical page of that slot |

## Verification
The hardest state to reach from the ports is a table that holds several live entries with the same page number: one global, others tagged with different address-space numbers, sitting at scattered slot indices. Only that state exercises lowest-index selection and the selective flushes. The bench first builds such a table with directed inserts, then probes it with matching and non-matching address-space numbers, and then flushes it. After that comes a long stretch of stimulus that draws page numbers from a range of eight and address-space numbers from a range of four. That stretch causes constant aliasing, pointer wraparound and overlapping operation requests in the same cycle. A behavioural model checks every cycle against the design.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PG_SHIFT = 13;
    localparam int VA_W     = 43;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = 28;
    localparam int ASN_W    = 8;
    localparam int MODES    = 4;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [ASN_W-1:0] asn;
        logic             glb;
        logic [PPN_W-1:0] ppn;
        logic [MODES-1:0] rd_en;
        logic [MODES-1:0] wr_en;
        logic             f_rd;
        logic             f_wr;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  tlb_entry_t [DEPTH-1:0] tbl,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [ASN_W-1:0]       asn,
    output logic [DEPTH-1:0]       match
);
    // one comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = tbl[g].valid && (tbl[g].tag == vpn) &&
                          (tbl[g].glb || (tbl[g].asn == asn));
    end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
    parameter int DEPTH = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/tlb_slot_ptr.sv
module tlb_slot_ptr #(
    parameter int DEPTH = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] ptr_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (clr)
            ptr_d = '0;
        else if (step)
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST); // R4
    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr_q == '0); // R5
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    output logic             lk_global,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic             fl_all,
    input  logic             fl_local,
    input  logic             fl_addr,
    input  logic [VPN_W-1:0] fa_vpn,
    input  logic [ASN_W-1:0] fa_asn,
    input  logic             slot_adv,
    output logic [IDX_W-1:0] slot_idx,
    output logic             slot_valid,
    output logic [VPN_W-1:0] slot_vpn,
    output logic [ASN_W-1:0] slot_asn,
    output logic             slot_global,
    output logic [PPN_W-1:0] slot_ppn
);
    typedef struct packed {
        tlb_entry_t [DEPTH-1:0] tbl;
    } tlb_state_t;

    tlb_state_t       st_d, st_q;
    logic [DEPTH-1:0] lk_match, fa_match;
    logic [IDX_W-1:0] ptr_q;
    tlb_entry_t       lk_ent, slot_ent, new_ent;
    logic             ptr_clr, ptr_step;

    tlb_match #(.DEPTH(DEPTH)) i_lk_match (
        .tbl(st_q.tbl), .vpn(lk_vpn), .asn(lk_asn), .match(lk_match));

    tlb_match #(.DEPTH(DEPTH)) i_fa_match (
        .tbl(st_q.tbl), .vpn(fa_vpn), .asn(fa_asn), .match(fa_match));

    tlb_first_set #(.DEPTH(DEPTH)) i_first (
        .req(lk_match), .any(lk_hit), .idx(lk_idx));

    assign ptr_clr  = fl_all;
    assign ptr_step = !fl_all && (ins_en || slot_adv);

    tlb_slot_ptr #(.DEPTH(DEPTH)) i_ptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .step(ptr_step), .ptr_q(ptr_q));

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.tag   = ins_vpn;
        new_ent.asn   = ins_asn;
        new_ent.glb   = ins_global;
        new_ent.ppn   = ins_ppn;
        new_ent.rd_en = ins_rd_en;
        new_ent.wr_en = ins_wr_en;
        new_ent.f_rd  = ins_fault_rd;
        new_ent.f_wr  = ins_fault_wr;
    end

    // next-state: one table operation per cycle, fixed priority
    always_comb begin
        st_d = st_q;
        if (fl_all) begin
            for (int i = 0; i < DEPTH; i++) st_d.tbl[i].valid = 1'b0;
        end else if (ins_en) begin
            st_d.tbl[ptr_q] = new_ent;
        end else if (fl_local) begin
            for (int i = 0; i < DEPTH; i++)
                if (!st_q.tbl[i].glb) st_d.tbl[i].valid = 1'b0;
        end else if (fl_addr) begin
            for (int i = 0; i < DEPTH; i++)
                if (fa_match[i]) st_d.tbl[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_ent      = lk_hit ? st_q.tbl[lk_idx] : '0;
    assign lk_ppn      = lk_ent.ppn;
    assign lk_rd_en    = lk_ent.rd_en;
    assign lk_wr_en    = lk_ent.wr_en;
    assign lk_fault_rd = lk_ent.f_rd;
    assign lk_fault_wr = lk_ent.f_wr;
    assign lk_global   = lk_ent.glb;

    assign slot_ent    = st_q.tbl[ptr_q];
    assign slot_idx    = ptr_q;
    assign slot_valid  = slot_ent.valid;
    assign slot_vpn    = slot_ent.tag;
    assign slot_asn    = slot_ent.asn;
    assign slot_global = slot_ent.glb;
    assign slot_ppn    = slot_ent.ppn;

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> !lk_hit && !slot_valid && slot_idx == '0); // R5
    AST_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_local && !fl_all && !ins_en) |=> (!lk_hit || lk_global)); // R6
    AST_ADDR_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_addr && !fl_all && !ins_en && !fl_local) ##1
        (lk_vpn == $past(fa_vpn) && lk_asn == $past(fa_asn)) |-> !lk_hit); // R7
    AST_INSERT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !fl_all) ##1
        (lk_vpn == $past(ins_vpn) && lk_asn == $past(ins_asn)) |-> lk_hit); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !fl_all) |=>
        slot_idx == (($past(slot_idx) == IDX_W'(DEPTH - 1)) ? '0 : $past(slot_idx) + 1'b1)); // R9
endmodule

// File: tb/test_asn_tlb.sv
`timescale 1ns/1ps
module test_asn_tlb;
    import tlb_pkg::*;
    localparam int D  = 16;
    localparam int IW = $clog2(D);

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic [VPN_W-1:0] lk_vpn = '0, ins_vpn = '0, fa_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, fa_asn = '0;
    logic ins_en = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
    logic [PPN_W-1:0] ins_ppn = '0;
    logic [MODES-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic fl_all = 0, fl_local = 0, fl_addr = 0, slot_adv = 0;

    logic lk_hit, lk_fault_rd, lk_fault_wr, lk_global, slot_valid, slot_global;
    logic [IW-1:0] lk_idx, slot_idx;
    logic [PPN_W-1:0] lk_ppn, slot_ppn;
    logic [MODES-1:0] lk_rd_en, lk_wr_en;
    logic [VPN_W-1:0] slot_vpn;
    logic [ASN_W-1:0] slot_asn;

    asn_tlb #(.DEPTH(D)) i_asn_tlb (.*);

    // behavioural model
    bit        m_v[D];
    longint    m_tag[D];
    int        m_asn[D], m_ppn[D], m_rd[D], m_wr[D];
    bit        m_g[D], m_fr[D], m_fw[D];
    int        m_ptr;

    int checks = 0, failures = 0;
    string cur_req = "R10";
    bit done = 0;

    function automatic int m_find(longint vpn, int asn);
        for (int i = 0; i < D; i++)
            if (m_v[i] && m_tag[i] == vpn && (m_g[i] || m_asn[i] == asn)) return i;
        return -1;
    endfunction

    task automatic chk(string req, longint act, longint exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int k;
        longint ep, ap;
        k = m_find(lk_vpn, lk_asn);
        chk(cur_req, lk_hit, (k >= 0), "lk_hit (R1)");
        if (k >= 0) begin
            chk("R3", lk_idx, k, "lk_idx");
            ep = {m_ppn[k][PPN_W-1:0], m_rd[k][3:0], m_wr[k][3:0], m_fr[k], m_fw[k], m_g[k]};
        end else ep = 0;
        ap = {lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr, lk_global};
        chk("R2", ap, ep, "lookup payload");
        chk("R9", slot_idx, m_ptr, "slot_idx");
        chk("R9", slot_valid, m_v[m_ptr], "slot_valid");
        chk("R9", {slot_vpn, slot_asn, slot_global, slot_ppn},
            {m_tag[m_ptr][VPN_W-1:0], m_asn[m_ptr][ASN_W-1:0], m_g[m_ptr], m_ppn[m_ptr][PPN_W-1:0]},
            "slot contents");
    endtask

    task automatic model_step();
        bit hitv[D];
        for (int i = 0; i < D; i++)
            hitv[i] = m_v[i] && m_tag[i] == fa_vpn && (m_g[i] || m_asn[i] == fa_asn);
        if (fl_all) begin
            for (int i = 0; i < D; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            if (ins_en) begin
                m_v[m_ptr] = 1; m_tag[m_ptr] = ins_vpn; m_asn[m_ptr] = ins_asn;
                m_g[m_ptr] = ins_global; m_ppn[m_ptr] = ins_ppn;
                m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en;
                m_fr[m_ptr] = ins_fault_rd; m_fw[m_ptr] = ins_fault_wr;
            end else if (fl_local) begin
                for (int i = 0; i < D; i++) if (!m_g[i]) m_v[i] = 0;
            end else if (fl_addr) begin
                for (int i = 0; i < D; i++) if (hitv[i]) m_v[i] = 0;
            end
            if (ins_en || slot_adv) m_ptr = (m_ptr + 1) % D;
        end
    endtask

    task automatic tick();
        #1;
        compare();
        model_step();
        @(negedge clk);
        ins_en = 0; fl_all = 0; fl_local = 0; fl_addr = 0; slot_adv = 0;
    endtask

    task automatic ins(int vpn, int asn, bit g, int ppn);
        ins_en = 1; ins_vpn = VPN_W'(vpn); ins_asn = ASN_W'(asn); ins_global = g;
        ins_ppn = PPN_W'(ppn); ins_rd_en = 4'(ppn); ins_wr_en = 4'(ppn >> 4);
        ins_fault_rd = ppn[0]; ins_fault_wr = ppn[1];
        tick();
    endtask

    task automatic probe(int vpn, int asn);
        lk_vpn = VPN_W'(vpn); lk_asn = ASN_W'(asn);
        tick();
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) begin
            m_v[i] = 0; m_tag[i] = 0; m_asn[i] = 0; m_g[i] = 0; m_ppn[i] = 0;
            m_rd[i] = 0; m_wr[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: empty after reset
        cur_req = "R10";
        probe(0, 0); probe(5, 3);
        // R4 / R1: basic inserts and probes
        cur_req = "R4";
        ins(1, 1, 0, 'h111); ins(2, 2, 0, 'h222); ins(3, 9, 1, 'h333); ins(4, 4, 0, 'h4a4);
        cur_req = "R1";
        probe(1, 1); probe(1, 2); probe(3, 0); probe(3, 200); probe(4, 4); probe(6, 4);
        // R3: aliases of one page, lowest index wins
        cur_req = "R3";
        ins(7, 5, 0, 'h701); ins(7, 6, 1, 'h702); ins(7, 5, 0, 'h703);
        probe(7, 5); probe(7, 6); probe(7, 0);
        // R2: insert then probe in the same cycle sees old contents
        cur_req = "R2";
        lk_vpn = 8; lk_asn = 1; ins(8, 1, 0, 'h808); probe(8, 1);
        // R6: local flush
        cur_req = "R6";
        fl_local = 1; tick();
        probe(1, 1); probe(3, 1); probe(7, 6); probe(7, 5);
        // R7: address flush removes a global alias too
        cur_req = "R7";
        ins(9, 3, 0, 'h909); ins(9, 4, 0, 'h90a);
        fa_vpn = 9; fa_asn = 3; fl_addr = 1; tick();
        probe(9, 3); probe(9, 4);
        fa_vpn = 7; fa_asn = 1; fl_addr = 1; tick();
        probe(7, 6);
        // R8: overlapping requests
        cur_req = "R8";
        ins_en = 1; ins_vpn = 10; ins_asn = 1; ins_global = 0; ins_ppn = 'haaa;
        fl_local = 1; tick();                      // insert wins
        probe(10, 1); probe(3, 1);
        fl_local = 1; fl_addr = 1; fa_vpn = 3; fa_asn = 1; tick(); // local wins
        probe(3, 1);
        ins_en = 1; ins_vpn = 11; fl_all = 1; tick(); // flush wins
        probe(11, 1); probe(3, 1);
        // R9: slot port stepping and combined step
        cur_req = "R9";
        ins(12, 2, 0, 'hc0c);
        slot_adv = 1; tick(); slot_adv = 1; tick();
        ins_en = 1; ins_vpn = 13; ins_asn = 2; slot_adv = 1; tick();
        probe(13, 2);
        // R4: wrap the pointer
        cur_req = "R4";
        for (int n = 0; n < D + 5; n++) ins(20 + n, n & 3, n[2], 'h100 + n);
        probe(20, 0); probe(20 + D + 4, (D + 4) & 3);
        // R5: flush everything
        cur_req = "R5";
        fl_all = 1; tick();
        probe(20 + D + 4, (D + 4) & 3);
        // R8 mixed stress with heavy aliasing
        cur_req = "R8";
        for (int c = 0; c < 3000; c++) begin
            lk_vpn = VPN_W'($urandom % 8); lk_asn = ASN_W'($urandom % 4);
            fa_vpn = VPN_W'($urandom % 8); fa_asn = ASN_W'($urandom % 4);
            ins_vpn = VPN_W'($urandom % 8); ins_asn = ASN_W'($urandom % 4);
            ins_global = ($urandom % 4) == 0; ins_ppn = PPN_W'($urandom);
            ins_rd_en = 4'($urandom); ins_wr_en = 4'($urandom);
            ins_fault_rd = 1'($urandom); ins_fault_wr = 1'($urandom);
            fl_all = ($urandom % 64) == 0;
            ins_en = ($urandom % 3) == 0;
            fl_local = ($urandom % 12) == 0;
            fl_addr = ($urandom % 6) == 0;
            slot_adv = ($urandom % 4) == 0;
            tick();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule